// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block sits between a host processor and two UART channels and carries every register access the host makes. The host drives an asynchronous bus: an active-low chip select, a channel-select line, a 3-bit register address, an 8-bit data byte, and separate active-low read and write strobes. The block synchronises these pins to its own clock. It decodes which channel and which of eight register locations is meant, commits writes on the trailing edge of the write strobe, and presents the addressed byte for reads. The data bus is split into an input byte, an output byte and an output enable, so the pad ring can build the bidirectional bus.

Each channel owns an alternate function register and a modem control register. When the broadcast bit of an alternate function register is set, a single host write updates the addressed location in both channels. This is handy when both channels must be programmed the same way. Each channel also drives an active-low multi-function output. The alternate function register selects what that output shows: the inverted OP2 modem control bit, the 16x baud clock, or the receive-ready indication. The register data is plain storage here; the serial, FIFO and baud logic that consumes it lives elsewhere. There is no streaming data path, so every pin is plain level-sensitive control or data and no valid/ready handshake applies.

Top module: `uart_dual_host_if`

## Requirements
- R1: After reset, every register location in both channels reads 0, except the modem control register at address 4, which reads 8'h08. Both multi-function outputs are low.
- R2: The 3-bit address selects one of eight byte locations in a channel. While `cs_n` is low, `chsel` = 1 selects channel A (index 1) and `chsel` = 0 selects channel B (index 0). A byte written to a location reads back unchanged from the same channel and address.
- R3: A write is committed once per write strobe, on the synchronised rising edge of `wr_n`. It is committed only if `cs_n` was low while the strobe was low. A write strobe with `cs_n` high changes no register.
- R4: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. `bus_dout` carries the addressed register of the selected channel no later than three clock cycles after the address and `chsel` settle.
- R5: When bit 0 of the alternate function register (address 2) is 1 in either channel, a committed write updates the addressed location in both channels regardless of `chsel`.
- R6: Reads are never broadcast. With the broadcast bit set, a read returns the register of the channel chosen by `chsel`.
- R7: Bits 2:1 of a channel's alternate function register select its `mf_n` output. Code 0 and code 3 give OP2 mode, where `mf_n` equals the inverse of modem control bit 3. Code 1 gives `mf_n` = inverse of that channel's `baud16x`. Code 2 gives `mf_n` = that channel's `rxrdy_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| chsel | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Write data from host bus |
| bus_dout | output | 8 | Read data toward host bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| baud16x | input | 2 | 16x baud clock per channel (bit 1 = A) |
| rxrdy_n | input | 2 | Receive-ready indication per channel, active low |
| mf_n | output | 2 | Multi-function output per channel, active low |

## Verification
The broadcast path is the hardest to reach from the ports, because it needs a prior write that arms bit 0 of an alternate function register. After arming, a later write through either value of `chsel` must land in both banks, while reads still separate the two channels. The bench first fills all sixteen locations with distinct bytes. It then arms broadcast through channel A, writes through channel B, and sweeps every location of both channels against its own model. Finally it disarms broadcast with one more broadcast write.

// File: rtl/uart_hif_pkg.sv
package uart_hif_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] AFR_ADDR = 3'd2;
  localparam logic [AW-1:0] MCR_ADDR = 3'd4;
  localparam logic [DW-1:0] MCR_RST  = 8'h08;
  localparam int OP2_BIT = 3;

  typedef enum logic [1:0] {
    MF_OP2     = 2'd0,
    MF_BAUD    = 2'd1,
    MF_RXRDY   = 2'd2,
    MF_OP2_ALT = 2'd3
  } mf_sel_e;
endpackage

// File: rtl/uart_hif_sync.sv
module uart_hif_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/uart_hif_bank.sv
module uart_hif_bank
  import uart_hif_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          bcast_en,
  output mf_sel_e       mf_sel,
  output logic          op2
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (AW'(i) == MCR_ADDR) ? MCR_RST : '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata    = regs[raddr];
  assign bcast_en = regs[AFR_ADDR][0];
  assign mf_sel   = mf_sel_e'(regs[AFR_ADDR][2:1]);
  assign op2      = regs[MCR_ADDR][OP2_BIT];
endmodule

// File: rtl/uart_hif_mfmux.sv
module uart_hif_mfmux
  import uart_hif_pkg::*;
(
  input  mf_sel_e sel,
  input  logic    op2,
  input  logic    baud16x,
  input  logic    rxrdy_n,
  output logic    mf_n
);
  always_comb begin
    unique case (sel)
      MF_BAUD:  mf_n = ~baud16x;
      MF_RXRDY: mf_n = rxrdy_n;
      default:  mf_n = ~op2;
    endcase
  end
endmodule

// File: rtl/uart_dual_host_if.sv
module uart_dual_host_if
  import uart_hif_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          chsel,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [1:0]    baud16x,
  input  logic [1:0]    rxrdy_n,
  output logic [1:0]    mf_n
);
  localparam int NCH = 2;
  localparam int SW  = 3 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, {AW{1'b0}}, {DW{1'b0}}};

  logic [SW-1:0] sync_q;
  logic          cs_s, chsel_s, wr_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;

  uart_hif_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, chsel, wr_n, addr, bus_din}),
    .q    (sync_q)
  );
  assign {cs_s, chsel_s, wr_s, addr_s, data_s} = sync_q;

  logic          cs_q, chsel_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      chsel_q <= 1'b0;
      wr_q    <= 1'b1;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      cs_q    <= cs_s;
      chsel_q <= chsel_s;
      wr_q    <= wr_s;
      addr_q  <= addr_s;
      data_q  <= data_s;
    end
  end

  logic wr_commit;
  assign wr_commit = wr_s & ~wr_q & ~cs_q;

  logic [NCH-1:0]  bcast_bits, op2_w, bank_we;
  mf_sel_e         mf_sel_w [NCH];
  logic [DW-1:0]   rdata_ch [NCH];
  logic            bcast;
  assign bcast = |bcast_bits;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign bank_we[c] = wr_commit & (bcast | (chsel_q == 1'(c)));

    uart_hif_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we[c]),
      .waddr   (addr_q),
      .wdata   (data_q),
      .raddr   (addr_s),
      .rdata   (rdata_ch[c]),
      .bcast_en(bcast_bits[c]),
      .mf_sel  (mf_sel_w[c]),
      .op2     (op2_w[c])
    );

    uart_hif_mfmux u_mf (
      .sel    (mf_sel_w[c]),
      .op2    (op2_w[c]),
      .baud16x(baud16x[c]),
      .rxrdy_n(rxrdy_n[c]),
      .mf_n   (mf_n[c])
    );
  end

  assign bus_dout = rdata_ch[chsel_s];
  assign bus_oe   = ~cs_n & ~rd_n;
endmodule

// File: rtl/uart_dual_host_if_chk.sv
module uart_dual_host_if_chk
  import uart_hif_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       bus_oe,
  input logic [1:0] bank_we,
  input logic [1:0] bcast_bits,
  input logic [1:0] op2_w,
  input logic [1:0] baud16x,
  input logic [1:0] rxrdy_n,
  input logic [1:0] mf_n,
  input logic [1:0] sel_a,
  input logic [1:0] sel_b
);
  AST_OE_OFF_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !bus_oe); // R4
  AST_OE_OFF_NO_RD: assert property (@(posedge clk) disable iff (!rst_n) rd_n |-> !bus_oe); // R4
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) (|bank_we) |=> !(|bank_we)); // R3
  AST_BCAST_ARMED: assert property (@(posedge clk) disable iff (!rst_n) (bank_we == 2'b11) |-> (|bcast_bits)); // R5
  AST_MF_OP2_A: assert property (@(posedge clk) disable iff (!rst_n) (sel_a == 2'd0 || sel_a == 2'd3) |-> (mf_n[1] == !op2_w[1])); // R7
  AST_MF_BAUD_B: assert property (@(posedge clk) disable iff (!rst_n) (sel_b == 2'd1) |-> (mf_n[0] == !baud16x[0])); // R7
  AST_MF_RXRDY_A: assert property (@(posedge clk) disable iff (!rst_n) (sel_a == 2'd2) |-> (mf_n[1] == rxrdy_n[1])); // R7
endmodule

bind uart_dual_host_if uart_dual_host_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .bus_oe    (bus_oe),
  .bank_we   (bank_we),
  .bcast_bits(bcast_bits),
  .op2_w     (op2_w),
  .baud16x   (baud16x),
  .rxrdy_n   (rxrdy_n),
  .mf_n      (mf_n),
  .sel_a     (mf_sel_w[1]),
  .sel_b     (mf_sel_w[0])
);

// File: tb/uart_dual_host_if_test.sv
module uart_dual_host_if_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, chsel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [1:0] baud16x = '0, rxrdy_n = 2'b11, mf_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [2][8];

  always #4 clk = ~clk;

  uart_dual_host_if uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chsel(chsel), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .baud16x(baud16x), .rxrdy_n(rxrdy_n), .mf_n(mf_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic ch, input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
    cs_n = ~sel; chsel = ch; addr = a; bus_din = d;
    cyc(2); wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(5);
    cs_n = 1'b1; cyc(2);
    if (sel) begin
      if (model[0][2][0] | model[1][2][0]) begin
        model[0][a] = d; model[1][a] = d;
      end else model[ch][a] = d;
    end
  endtask

  task automatic host_rd(input logic ch, input logic [2:0] a, output logic [7:0] d, output logic oe);
    cs_n = 1'b0; chsel = ch; addr = a; rd_n = 1'b0;
    cyc(4); d = bus_dout; oe = bus_oe;
    rd_n = 1'b1; cs_n = 1'b1; cyc(1);
  endtask

  task automatic sweep(input string req);
    logic [7:0] d; logic oe;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) begin
        host_rd(1'(c), 3'(a), d, oe);
        check(req, {24'd0, d}, {24'd0, model[c][a]});
        check("R4 oe during read", {31'd0, oe}, 32'd1);
      end
  endtask

  initial begin
    #1600000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d; logic oe;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) model[c][a] = (a == 4) ? 8'h08 : 8'h00;
    cyc(3); rst_n = 1'b1; cyc(3);

    // R1 reset state
    check("R1 mf_n after reset", {30'd0, mf_n}, 32'd0);
    check("R4 oe idle", {31'd0, bus_oe}, 32'd0);
    sweep("R1 reset value");

    // R4: read strobe without chip select leaves bus off
    rd_n = 1'b0; cyc(3);
    check("R4 oe with cs_n high", {31'd0, bus_oe}, 32'd0);
    rd_n = 1'b1; cyc(1);

    // R2 distinct fill of every location, bit 0 of address 2 kept clear
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++)
        host_wr(1'(c), 3'(a), 8'(8'h40 + c * 8'h10 + a * 8'h02 + ((a == 2) ? 0 : 1) * 8'h80));
    sweep("R2 readback");

    // R3 strobe with cs_n high ignored
    host_wr(1'b1, 3'd5, 8'hEE, 1'b0);
    host_wr(1'b0, 3'd5, 8'hDD, 1'b0);
    sweep("R3 write without chip select ignored");

    // R5 arm broadcast via channel A, write through channel B
    host_wr(1'b1, 3'd2, 8'h01);
    host_wr(1'b0, 3'd6, 8'h5A);
    host_wr(1'b1, 3'd3, 8'hA5);
    check("R5 broadcast model", {24'd0, model[1][6]}, 32'h5A);
    sweep("R5/R6 broadcast then per-channel read");
    host_wr(1'b0, 3'd2, 8'h00);
    sweep("R5 broadcast disarm");

    // R7 multi-function output, every mode, op2, baud and rxrdy combination
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 4; m++)
        for (int o = 0; o < 2; o++) begin
          host_wr(1'(c), 3'd2, 8'(m << 1));
          host_wr(1'(c), 3'd4, 8'(o << 3));
          for (int b = 0; b < 2; b++)
            for (int r = 0; r < 2; r++) begin
              baud16x[c] = 1'(b); rxrdy_n[c] = 1'(r); cyc(1);
              check("R7 mf_n", {31'd0, mf_n[c]},
                    {31'd0, (m == 1) ? 1'(~b) : (m == 2) ? 1'(r) : 1'(~o)});
            end
        end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule